// File: doc/BRIEF.md
# Timeslot Regulator Enable Sequencer

This block drives the enable lines of four low-dropout regulators in a power management controller. It watches a top-level power state (off, pre-active, start-up, active, shutdown) and a slot timer made of a slot index and a strobe. During start-up each regulator switches on in the timeslot that software programmed for it, so the in-rush current is spread over time. During shutdown each regulator switches off in its own programmed slot. A regulator with no shutdown slot is switched off once the controller is in the off state.

Software reaches the block through a plain register port with a write strobe, an address, write data and combinational read data. The enable register answers at two aliased addresses that share one storage. Two more registers hold the start slots and the stop slots. In the active state an enable write acts on the regulator at once. An enable write made in the pre-active state is held back and only applied when the controller enters the active state.

Top module: `ldo_slot_sequencer`

## Requirements
- R1: After a synchronous active-low reset, all regulator outputs are 0, the enable register reads 0, both slot registers read 0 and no held write is pending.
- R2: The enable register answers at address 0x0D and at address 0xB0 with the same storage. The enable for regulator 0 is at bit 10, regulator 1 at bit 11, regulator 2 at bit 8 and regulator 3 at bit 9. Every other bit reads 0. The enable bit reads back as the live state of its regulator output.
- R3: In the active state (code 3), a write to the enable register sets every regulator output to its written bit on the next clock edge.
- R4: In the pre-active state (code 1), an enable write changes no output and no readable bit. It is held and applied on the first clock edge where the state is active after a different state. An enable write in that same cycle takes priority over it.
- R5: In the start-up state (code 2), on a clock edge where the strobe is high and the slot index equals a regulator's nonzero start slot, that regulator's output and enable bit become 1. A start slot of 0 never starts the regulator, and no action happens while the strobe is low.
- R6: In the shutdown state (code 4), on a clock edge where the strobe is high and the slot index equals a regulator's stop slot in the range 1 to 14, that regulator's output and enable bit become 0.
- R7: A regulator whose stop slot is 0 or 15 has no shutdown slot. Such a regulator is cleared on every clock edge in the off state (code 0) and is never cleared by a shutdown strobe.
- R8: Enable writes made in the off, start-up or shutdown state are ignored.
- R9: Any held enable write is discarded on a clock edge in the shutdown state, so a later entry into the active state does not apply it.
- R10: The start-slot register is at address 0x20 and the stop-slot register is at 0x21, with regulator i in bits 4i+3 to 4i. Both can be written in any state and read back. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pm_state | input | 3 | Power state: 0 off, 1 pre-active, 2 start-up, 3 active, 4 shutdown |
| slot_idx | input | 4 | Current timeslot number from the sequence timer |
| slot_stb | input | 1 | High for one cycle when the timeslot in slot_idx is reached |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address for read and write |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for bus_addr (combinational) |
| ldo_en | output | 4 | Regulator enable outputs, bit i for regulator i |

## Verification
The bench targets the held pre-active write. A design that applied it at once would switch a regulator on early, and one that failed to discard it in shutdown would switch a regulator on when the active state is re-entered. Stop slot 15 is strobed on purpose: a design that treated it as a real slot would clear the regulator during shutdown instead of in the off state. The bench also uses a start slot of 0, strobes with the strobe low, and writes to the alias address. These catch a sequencer that starts unprogrammed regulators, one that acts without a strobe, and one whose second address or bit order is wrong. Writes made in the start-up, shutdown and off states must leave the outputs unchanged, which catches a design that does not gate enable writes by state.

// File: rtl/ldo_seq_pkg.sv
package ldo_seq_pkg;

   typedef enum logic [2:0] {
      PM_OFF    = 3'd0,
      PM_PRE    = 3'd1,
      PM_START  = 3'd2,
      PM_ACTIVE = 3'd3,
      PM_SHUT   = 3'd4
   } pm_state_e;

   // Register bit that carries the enable of regulator idx: the upper half of
   // the regulators sits below the lower half, starting at bit lsb.
   function automatic int en_bit_pos(input int idx, input int n, input int lsb);
      return lsb + ((idx + n / 2) % n);
   endfunction

endpackage

// File: rtl/ldo_seq_slotregs.sv
module ldo_seq_slotregs #(
   parameter int NUM_REG  = 4,
   parameter int SLOT_W   = 4,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 16,
   parameter logic [ADDR_W-1:0] START_ADDR = 8'h20,
   parameter logic [ADDR_W-1:0] STOP_ADDR  = 8'h21
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_wr,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [DATA_W-1:0]         bus_wdata,
   output logic [NUM_REG*SLOT_W-1:0] start_flat,
   output logic [NUM_REG*SLOT_W-1:0] stop_flat
);

   localparam int FLAT_W = NUM_REG * SLOT_W;

   if (FLAT_W > DATA_W) begin : g_bad_width
      $error("slot fields do not fit the data width");
   end

   logic [FLAT_W-1:0] start_q;
   logic [FLAT_W-1:0] stop_q;
   logic              wr_start;
   logic              wr_stop;

   assign wr_start = bus_wr && (bus_addr == START_ADDR);
   assign wr_stop  = bus_wr && (bus_addr == STOP_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         stop_q  <= '0;
      end else begin
         if (wr_start) start_q <= bus_wdata[FLAT_W-1:0];
         if (wr_stop)  stop_q  <= bus_wdata[FLAT_W-1:0];
      end
   end

   assign start_flat = start_q;
   assign stop_flat  = stop_q;

   // R10: a slot write is visible on the following cycle
   a_r10_start_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |=> start_flat == $past(bus_wdata[FLAT_W-1:0]));
   a_r10_stop_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stop |=> stop_flat == $past(bus_wdata[FLAT_W-1:0]));

endmodule

// File: rtl/ldo_seq_chan.sv
module ldo_seq_chan
   import ldo_seq_pkg::*;
#(
   parameter int SLOT_W    = 4,
   parameter int STOP_MAX  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  pm_state_e         state,
   input  logic              enter_active,
   input  logic [SLOT_W-1:0] slot_idx,
   input  logic              slot_stb,
   input  logic              wr_en,
   input  logic              wr_bit,
   input  logic [SLOT_W-1:0] start_slot,
   input  logic [SLOT_W-1:0] stop_slot,
   output logic              en
);

   if (STOP_MAX >= (1 << SLOT_W)) begin : g_bad_stop
      $error("stop slot range does not fit the slot width");
   end

   logic en_q;
   logic pend_v;
   logic pend_d;
   logic start_hit;
   logic stop_assigned;
   logic stop_hit;

   assign start_hit     = slot_stb && (start_slot != '0) && (slot_idx == start_slot);
   assign stop_assigned = (stop_slot != '0) && (int'(stop_slot) <= STOP_MAX);
   assign stop_hit      = slot_stb && stop_assigned && (slot_idx == stop_slot);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         pend_v <= 1'b0;
         pend_d <= 1'b0;
      end else begin
         case (state)
            PM_PRE: begin
               if (wr_en) begin
                  pend_v <= 1'b1;
                  pend_d <= wr_bit;
               end
            end
            PM_ACTIVE: begin
               if (enter_active) begin
                  pend_v <= 1'b0;
                  if (pend_v) en_q <= pend_d;
               end
               if (wr_en) en_q <= wr_bit;
            end
            PM_START: begin
               if (start_hit) en_q <= 1'b1;
            end
            PM_SHUT: begin
               pend_v <= 1'b0;
               if (stop_hit) en_q <= 1'b0;
            end
            PM_OFF: begin
               if (!stop_assigned) en_q <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   assign en = en_q;

   a_r3_active_write: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_ACTIVE && wr_en) |=> en == $past(wr_bit));
   a_r4_pre_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_PRE) |=> en == $past(en));
   a_r5_start_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_START && slot_stb && start_slot != '0 && slot_idx == start_slot) |=> en);
   a_r5_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_START && !slot_stb) |=> en == $past(en));
   a_r6_stop_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_SHUT && slot_stb && stop_slot != '0 && int'(stop_slot) <= STOP_MAX
       && slot_idx == stop_slot) |=> !en);
   a_r7_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_OFF && (stop_slot == '0 || int'(stop_slot) > STOP_MAX)) |=> !en);
   a_r8_shut_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_SHUT && !en) |=> !en);

endmodule

// File: rtl/ldo_slot_sequencer.sv
module ldo_slot_sequencer
   import ldo_seq_pkg::*;
#(
   parameter int NUM_REG   = 4,
   parameter int SLOT_W    = 4,
   parameter int STOP_MAX  = 14,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 16,
   parameter int EN_LSB    = 8,
   parameter logic [ADDR_W-1:0] EN_ADDR_A  = 8'h0D,
   parameter logic [ADDR_W-1:0] EN_ADDR_B  = 8'hB0,
   parameter logic [ADDR_W-1:0] START_ADDR = 8'h20,
   parameter logic [ADDR_W-1:0] STOP_ADDR  = 8'h21
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         pm_state,
   input  logic [SLOT_W-1:0]  slot_idx,
   input  logic               slot_stb,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic [NUM_REG-1:0] ldo_en
);

   localparam int FLAT_W = NUM_REG * SLOT_W;

   if (EN_LSB + NUM_REG > DATA_W) begin : g_bad_en
      $error("enable field does not fit the data width");
   end
   if (NUM_REG % 2 != 0) begin : g_bad_count
      $error("regulator count must be even for the enable bit order");
   end

   pm_state_e         state;
   pm_state_e         prev_state;
   logic              enter_active;
   logic              en_addr_hit;
   logic              en_wr;
   logic [FLAT_W-1:0] start_flat;
   logic [FLAT_W-1:0] stop_flat;
   logic [DATA_W-1:0] en_word;

   assign state        = pm_state_e'(pm_state);
   assign enter_active = (state == PM_ACTIVE) && (prev_state != PM_ACTIVE);
   assign en_addr_hit  = (bus_addr == EN_ADDR_A) || (bus_addr == EN_ADDR_B);
   assign en_wr        = bus_wr && en_addr_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_state <= PM_OFF;
      else        prev_state <= state;
   end

   ldo_seq_slotregs #(
      .NUM_REG   (NUM_REG),
      .SLOT_W    (SLOT_W),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .START_ADDR(START_ADDR),
      .STOP_ADDR (STOP_ADDR)
   ) u_slots (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .start_flat(start_flat),
      .stop_flat (stop_flat)
   );

   for (genvar i = 0; i < NUM_REG; i++) begin : g_chan
      localparam int BITP = en_bit_pos(i, NUM_REG, EN_LSB);

      ldo_seq_chan #(
         .SLOT_W  (SLOT_W),
         .STOP_MAX(STOP_MAX)
      ) u_chan (
         .clk         (clk),
         .rst_n       (rst_n),
         .state       (state),
         .enter_active(enter_active),
         .slot_idx    (slot_idx),
         .slot_stb    (slot_stb),
         .wr_en       (en_wr),
         .wr_bit      (bus_wdata[BITP]),
         .start_slot  (start_flat[i*SLOT_W +: SLOT_W]),
         .stop_slot   (stop_flat[i*SLOT_W +: SLOT_W]),
         .en          (ldo_en[i])
      );

      assign en_word[BITP] = ldo_en[i];
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_pad
      if (b < EN_LSB || b >= EN_LSB + NUM_REG) begin : g_zero
         assign en_word[b] = 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (en_addr_hit)               bus_rdata = en_word;
      else if (bus_addr == START_ADDR) bus_rdata[FLAT_W-1:0] = start_flat;
      else if (bus_addr == STOP_ADDR)  bus_rdata[FLAT_W-1:0] = stop_flat;
   end

   // R2: both aliases return identical data
   a_r2_alias_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == EN_ADDR_B) |-> bus_rdata[EN_LSB +: NUM_REG] == en_word[EN_LSB +: NUM_REG]
                                  && $countones(bus_rdata) == $countones(ldo_en));
   // R8: writes outside pre-active and active leave outputs unchanged unless a slot acts
   a_r8_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
      (en_wr && state == PM_START && !slot_stb) |=> ldo_en == $past(ldo_en));

endmodule

// File: tb/sim_ldo_slot_sequencer.sv
`timescale 1ns/1ps
module sim_ldo_slot_sequencer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  pm_state = 3'd0;
   logic [3:0]  slot_idx = 4'd0;
   logic        slot_stb = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [15:0] bus_wdata = 16'h0000;
   logic [15:0] bus_rdata;
   logic [3:0]  ldo_en;

   always #2 clk = ~clk;

   ldo_slot_sequencer u0 (
      .clk(clk), .rst_n(rst_n), .pm_state(pm_state), .slot_idx(slot_idx),
      .slot_stb(slot_stb), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ldo_en(ldo_en)
   );

   int    n_vec = 0;
   int    n_bad = 0;
   string phase = "R1";
   bit    done = 1'b0;

   // reference model state
   int m_en[4];
   int m_pv[4];
   int m_pd[4];
   int m_start[4];
   int m_stop[4];
   int m_prev;

   function automatic int bitpos(input int i);
      case (i)
         0: return 10;
         1: return 11;
         2: return 8;
         default: return 9;
      endcase
   endfunction

   function automatic logic [15:0] m_read(input logic [7:0] a);
      logic [15:0] r;
      r = 16'h0000;
      if (a == 8'h0D || a == 8'hB0) begin
         for (int i = 0; i < 4; i++) if (m_en[i] != 0) r[bitpos(i)] = 1'b1;
      end else if (a == 8'h20) begin
         for (int i = 0; i < 4; i++) r[4*i +: 4] = m_start[i][3:0];
      end else if (a == 8'h21) begin
         for (int i = 0; i < 4; i++) r[4*i +: 4] = m_stop[i][3:0];
      end
      return r;
   endfunction

   always @(posedge clk) begin
      int st;
      bit enw;
      st  = int'(pm_state);
      enw = bus_wr && (bus_addr == 8'h0D || bus_addr == 8'hB0);
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin
            m_en[i] = 0; m_pv[i] = 0; m_pd[i] = 0; m_start[i] = 0; m_stop[i] = 0;
         end
         m_prev = 0;
      end else begin
         for (int i = 0; i < 4; i++) begin
            int wb;
            bit unassigned;
            wb = int'(bus_wdata[bitpos(i)]);
            unassigned = (m_stop[i] == 0 || m_stop[i] > 14);
            if (st == 1 && enw) begin
               m_pv[i] = 1; m_pd[i] = wb;
            end else if (st == 3) begin
               if (m_prev != 3) begin
                  if (m_pv[i] != 0) m_en[i] = m_pd[i];
                  m_pv[i] = 0;
               end
               if (enw) m_en[i] = wb;
            end else if (st == 2) begin
               if (slot_stb && m_start[i] != 0 && int'(slot_idx) == m_start[i]) m_en[i] = 1;
            end else if (st == 4) begin
               m_pv[i] = 0;
               if (slot_stb && !unassigned && int'(slot_idx) == m_stop[i]) m_en[i] = 0;
            end else if (st == 0) begin
               if (unassigned) m_en[i] = 0;
            end
         end
         if (bus_wr && bus_addr == 8'h20)
            for (int i = 0; i < 4; i++) m_start[i] = int'(bus_wdata[4*i +: 4]);
         if (bus_wr && bus_addr == 8'h21)
            for (int i = 0; i < 4; i++) m_stop[i] = int'(bus_wdata[4*i +: 4]);
         m_prev = st;
      end
   end

   // per-clock comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [3:0]  exp_en;
         logic [15:0] exp_rd;
         for (int i = 0; i < 4; i++) exp_en[i] = (m_en[i] != 0);
         exp_rd = m_read(bus_addr);
         n_vec++;
         if (ldo_en !== exp_en) begin
            n_bad++;
            $display("FAIL %s ldo_en actual=%b expected=%b at %0t", phase, ldo_en, exp_en, $time);
         end
         n_vec++;
         if (bus_rdata !== exp_rd) begin
            n_bad++;
            $display("FAIL %s rdata@%h actual=%h expected=%h at %0t", phase, bus_addr, bus_rdata, exp_rd, $time);
         end
      end
   end

   task automatic drive(input int st, input int idx, input bit stb, input bit wr,
                        input logic [7:0] a, input logic [15:0] d);
      @(posedge clk); #1;
      pm_state = st[2:0]; slot_idx = idx[3:0]; slot_stb = stb;
      bus_wr = wr; bus_addr = a; bus_wdata = d;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #1;
         slot_stb = 1'b0; bus_wr = 1'b0;
      end
   endtask

   // directed check with a constant expected value, sampled at the next negedge
   task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s directed actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog expired in phase %s", phase);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset state
      phase = "R1";
      idle(2);
      @(negedge clk);
      check({12'h0, ldo_en}, 16'h0, "R1");
      bus_addr = 8'h0D; #0.5; check(bus_rdata, 16'h0, "R1");

      // R10: slot registers, state off
      phase = "R10";
      drive(0, 0, 0, 1, 8'h20, 16'h0321);
      drive(0, 0, 0, 1, 8'h21, 16'h1F03);
      drive(0, 0, 0, 0, 8'h20, 16'h0);
      @(negedge clk); check(bus_rdata, 16'h0321, "R10");
      drive(0, 0, 0, 0, 8'h21, 16'h0);
      @(negedge clk); check(bus_rdata, 16'h1F03, "R10");
      drive(0, 0, 0, 0, 8'h22, 16'h0);
      @(negedge clk); check(bus_rdata, 16'h0, "R10");

      // R8: write in off ignored
      phase = "R8";
      drive(0, 0, 0, 1, 8'h0D, 16'h0F00);
      idle(1);
      @(negedge clk); check({12'h0, ldo_en}, 16'h0, "R8");

      // R4: held write in pre-active
      phase = "R4";
      drive(1, 0, 0, 1, 8'h0D, 16'h0F00);
      idle(2);
      @(negedge clk); check({12'h0, ldo_en}, 16'h0, "R4");
      check(bus_rdata, 16'h0, "R4");

      // R5: start-up slots, strobe low first
      phase = "R5";
      drive(2, 1, 0, 0, 8'h0D, 16'h0);
      idle(1);
      @(negedge clk); check({12'h0, ldo_en}, 16'h0, "R5");
      for (int s = 1; s <= 4; s++) drive(2, s, 1, 0, 8'h0D, 16'h0);
      drive(2, 0, 1, 0, 8'h0D, 16'h0);
      idle(1);
      @(negedge clk); check({12'h0, ldo_en}, 16'h0007, "R5");

      // R4: entering active applies the held write
      phase = "R4";
      drive(3, 0, 0, 0, 8'h0D, 16'h0);
      idle(1);
      @(negedge clk); check({12'h0, ldo_en}, 16'h000F, "R4");

      // R3 / R2: direct writes and alias
      phase = "R3";
      drive(3, 0, 0, 1, 8'hB0, 16'h0400);
      idle(1);
      @(negedge clk); check({12'h0, ldo_en}, 16'h0001, "R3");
      phase = "R2";
      check(bus_rdata, 16'h0400, "R2");
      drive(3, 0, 0, 1, 8'h0D, 16'h0A00);
      drive(3, 0, 0, 0, 8'hB0, 16'h0);
      @(negedge clk); check({12'h0, ldo_en}, 16'h000A, "R2");
      check(bus_rdata, 16'h0A00, "R2");
      drive(3, 0, 0, 1, 8'hB0, 16'hFFFF);
      drive(3, 0, 0, 0, 8'h0D, 16'h0);
      @(negedge clk); check(bus_rdata, 16'h0F00, "R2");

      // R8 / R6: shutdown, ignored write, slots
      phase = "R8";
      drive(4, 0, 0, 1, 8'h0D, 16'h0000);
      idle(1);
      @(negedge clk); check({12'h0, ldo_en}, 16'h000F, "R8");
      phase = "R6";
      drive(4, 1, 1, 0, 8'h0D, 16'h0);
      idle(1);
      @(negedge clk); check({12'h0, ldo_en}, 16'h0007, "R6");
      drive(4, 3, 1, 0, 8'h0D, 16'h0);
      drive(4, 15, 1, 0, 8'h0D, 16'h0);
      drive(4, 0, 1, 0, 8'h0D, 16'h0);
      idle(1);
      @(negedge clk); check({12'h0, ldo_en}, 16'h0006, "R7");

      // R7: off clears unassigned regulators
      phase = "R7";
      drive(0, 0, 0, 1, 8'h0D, 16'h0F00);
      idle(1);
      @(negedge clk); check({12'h0, ldo_en}, 16'h0, "R7");

      // R9: held write discarded by shutdown
      phase = "R9";
      drive(1, 0, 0, 1, 8'h0D, 16'h0F00);
      drive(4, 0, 0, 0, 8'h0D, 16'h0);
      drive(3, 0, 0, 0, 8'h0D, 16'h0);
      idle(2);
      @(negedge clk); check({12'h0, ldo_en}, 16'h0, "R9");

      // R8: write in start-up ignored and not held
      phase = "R8";
      drive(0, 0, 0, 0, 8'h0D, 16'h0);
      drive(2, 0, 0, 1, 8'h0D, 16'h0F00);
      drive(3, 0, 0, 0, 8'h0D, 16'h0);
      idle(2);
      @(negedge clk); check({12'h0, ldo_en}, 16'h0, "R8");

      // R1: reset in the middle clears everything
      phase = "R1";
      drive(3, 0, 0, 1, 8'h21, 16'h1111);
      drive(3, 0, 0, 1, 8'h0D, 16'h0F00);
      idle(1);
      @(posedge clk); #1 rst_n = 1'b0;
      @(posedge clk); #1 rst_n = 1'b1;
      bus_addr = 8'h21;
      @(negedge clk); check({12'h0, ldo_en}, 16'h0, "R1");
      check(bus_rdata, 16'h0, "R1");
      idle(2);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule